// File: doc/BRIEF.md
# Two-function bridge configuration register file

This block stores the byte-wide configuration space of a chipset bridge that presents two functions: function 0 is the host bridge and function 1 is the PCI-to-PCI bridge. A configuration access carries a function number, an 8-bit register offset, write data and separate read and write strobes. Writes take effect on the clock edge that samples the strobe. Read data is registered and is valid in the cycle after the read strobe.

Each function has its own write behaviour. Irregular offset ranges are read-only, and some registers take only part of a written byte. Status bytes clear a bit when a one is written to it. Reset contents come from two parameter images, one per function. Three host-bridge bytes (offsets 0x61, 0x62 and 0x63) drive output ports continuously, so a downstream shadow-memory decoder can use them without a read cycle.

Top module: `bridge_cfg_regs`

## Requirements
- R1: A read strobe to function 0 or 1 loads the byte stored at the given offset into `rd_data` at the next clock edge. `rd_data` keeps its value while no read strobe is present and resets to 0x00.
- R2: A read of any function number other than 0 or 1 returns 0xFF. A write to such a function changes no stored byte.
- R3: Function 0 ignores writes to offsets 0x00–0x03, 0x05–0x06, 0x08–0x0C, 0x0E–0x11, 0x14–0x4F, 0x79–0x7D, 0x85–0x87, 0x8C–0xA7 and 0xAD–0xFC.
- R4: Function 1 ignores writes to offsets 0x00–0x03, 0x05–0x06, 0x08–0x17, 0x1B, 0x1E–0x1F, 0x28–0x3D and 0x43–0xFF.
- R5: At offset 0x04, a write to function 0 changes only bit 6, and a write to function 1 changes only the bits in mask 0x47. Every other bit keeps its value.
- R6: At offset 0x07, each 1 written clears the matching stored bit: function 0 within mask 0xB0, function 1 within mask 0x30. All other bits are unchanged.
- R7: At function 0 offset 0x12, a write stores bits 7:4 and forces bits 3:0 to zero. Offset 0x13 stores the full byte.
- R8: At function 1 offsets 0x20, 0x22, 0x24 and 0x26, a write stores bits 7:4 and forces bits 3:0 to zero.
- R9: Reset loads every byte from its function's reset image. The one exception is function 0 offset 0x63, where bits 5:4 are forced to zero.
- R10: `shadow_c_o`, `shadow_d_o` and `shadow_ef_o` always equal function 0 bytes 0x61, 0x62 and 0x63. They update in the cycle after a write to those bytes.
- R11: A writable offset not named in R5–R8 stores the full written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_fn | input | FN_W (3) | Function number of the access |
| acc_off | input | OFF_W (8) | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| shadow_c_o | output | 8 | Function 0 byte 0x61 |
| shadow_d_o | output | 8 | Function 0 byte 0x62 |
| shadow_ef_o | output | 8 | Function 0 byte 0x63 |

## Verification
The assertions run on every cycle. They check that a byte at a protected offset keeps its value after a write attempt. They check that the non-writable bits of the command byte keep their value, and that the status byte equals its old value with the written ones cleared inside the function's mask. They also check that a read of an unimplemented function yields 0xFF, and that the forced bits of byte 0x63 are zero when reset ends. Several behaviours can only be shown by the bench's scenarios: the exact edges of each protected range, the nibble truncation of the aperture and window registers, full-byte storage elsewhere, isolation between functions, and the values on the shadow ports.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

   localparam int unsigned BYTE_W      = 8;
   localparam logic [7:0]  OFF_CMD     = 8'h04;
   localparam logic [7:0]  OFF_STS     = 8'h07;
   localparam logic [7:0]  OFF_SHD_C   = 8'h61;
   localparam logic [7:0]  OFF_SHD_D   = 8'h62;
   localparam logic [7:0]  OFF_SHD_EF  = 8'h63;
   localparam logic [7:0]  SHD_EF_RST_CLR = 8'h30;

   typedef enum logic [1:0] {
      WR_FULL,
      WR_MASKED,
      WR_CLEAR1,
      WR_NIBBLE
   } wr_kind_e;

   function automatic logic host_locked(input logic [7:0] o);
      return (o < 8'h04) ||
             (o >= 8'h05 && o <= 8'h06) ||
             (o >= 8'h08 && o <= 8'h0C) ||
             (o >= 8'h0E && o <= 8'h11) ||
             (o >= 8'h14 && o <= 8'h4F) ||
             (o >= 8'h79 && o <= 8'h7D) ||
             (o >= 8'h85 && o <= 8'h87) ||
             (o >= 8'h8C && o <= 8'hA7) ||
             (o >= 8'hAD && o <= 8'hFC);
   endfunction

   function automatic logic p2p_locked(input logic [7:0] o);
      return (o < 8'h04) ||
             (o >= 8'h05 && o <= 8'h06) ||
             (o >= 8'h08 && o <= 8'h17) ||
             (o == 8'h1B) ||
             (o >= 8'h1E && o <= 8'h1F) ||
             (o >= 8'h28 && o <= 8'h3D) ||
             (o >= 8'h43);
   endfunction

   function automatic logic [7:0] merge_byte(input wr_kind_e k,
                                             input logic [7:0] old,
                                             input logic [7:0] wd,
                                             input logic [7:0] mask);
      logic [7:0] r;
      unique case (k)
         WR_MASKED: r = (old & ~mask) | (wd & mask);
         WR_CLEAR1: r = old & ~(wd & mask);
         WR_NIBBLE: r = wd & 8'hF0;
         default:   r = wd;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/bcr_write_rules.sv
module bcr_write_rules
   import bcr_pkg::*;
#(
   parameter int unsigned FN_ID = 0,
   parameter int unsigned OFF_W = 8
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [BYTE_W-1:0] old_byte,
   input  logic [BYTE_W-1:0] wdata,
   output logic              locked,
   output logic [BYTE_W-1:0] next_byte
);

   wr_kind_e   kind;
   logic [7:0] mask;

   if (FN_ID > 1) begin : g_bad_fn
      $error("bcr_write_rules: FN_ID must be 0 or 1");
   end

   if (FN_ID == 0) begin : g_host
      always_comb begin
         locked = host_locked(off);
         kind   = WR_FULL;
         mask   = 8'hFF;
         unique case (off)
            OFF_CMD: begin kind = WR_MASKED; mask = 8'h40; end
            OFF_STS: begin kind = WR_CLEAR1; mask = 8'hB0; end
            8'h12:   begin kind = WR_NIBBLE; end
            default: ;
         endcase
      end
   end else begin : g_p2p
      always_comb begin
         locked = p2p_locked(off);
         kind   = WR_FULL;
         mask   = 8'hFF;
         unique case (off)
            OFF_CMD: begin kind = WR_MASKED; mask = 8'h47; end
            OFF_STS: begin kind = WR_CLEAR1; mask = 8'h30; end
            8'h20, 8'h22, 8'h24, 8'h26: kind = WR_NIBBLE;
            default: ;
         endcase
      end
   end

   assign next_byte = merge_byte(kind, old_byte, wdata, mask);

endmodule

// File: rtl/bcr_fn_bank.sv
module bcr_fn_bank
   import bcr_pkg::*;
#(
   parameter int unsigned FN_ID = 0,
   parameter int unsigned OFF_W = 8,
   localparam int unsigned DEPTH = 1 << OFF_W,
   parameter logic [DEPTH*BYTE_W-1:0] RESET_IMG = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [OFF_W-1:0]                  off,
   input  logic [BYTE_W-1:0]                 wdata,
   output logic [DEPTH-1:0][BYTE_W-1:0]      regs_o
);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [BYTE_W-1:0] old_byte;
   logic [BYTE_W-1:0] new_byte;
   logic              locked;

   assign old_byte = mem[off];

   bcr_write_rules #(.FN_ID(FN_ID), .OFF_W(OFF_W)) rules_i (
      .off       (off),
      .old_byte  (old_byte),
      .wdata     (wdata),
      .locked    (locked),
      .next_byte (new_byte)
   );

   function automatic logic [BYTE_W-1:0] rst_byte(input int unsigned idx);
      logic [BYTE_W-1:0] b;
      b = RESET_IMG[idx*BYTE_W +: BYTE_W];
      if (FN_ID == 0 && idx == int'(OFF_SHD_EF)) b = b & ~SHD_EF_RST_CLR;
      return b;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= rst_byte(i);
      end else if (wr_en && !locked) begin
         mem[off] <= new_byte;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_out
      assign regs_o[g] = mem[g];
   end

   // Checker state: remembers the previous write attempt.
   logic              chk_v;
   logic              chk_lock;
   logic [OFF_W-1:0]  chk_off;
   logic [BYTE_W-1:0] chk_old;
   logic [BYTE_W-1:0] chk_wd;

   localparam logic [7:0] CMD_KEEP = (FN_ID == 0) ? 8'h40 : 8'h47;
   localparam logic [7:0] STS_CLR  = (FN_ID == 0) ? 8'hB0 : 8'h30;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_v    <= 1'b0;
         chk_lock <= 1'b0;
         chk_off  <= '0;
         chk_old  <= '0;
         chk_wd   <= '0;
      end else begin
         chk_v    <= wr_en;
         chk_lock <= locked;
         chk_off  <= off;
         chk_old  <= old_byte;
         chk_wd   <= wdata;
      end
   end

   // R3 / R4: protected bytes keep their value
   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_lock) |-> (mem[chk_off] == chk_old));

   p_cmd_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_off == OFF_CMD) |-> (((mem[OFF_CMD] ^ chk_old) & ~CMD_KEEP) == 8'h00));

   p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_v && chk_off == OFF_STS) |-> (mem[OFF_STS] == (chk_old & ~(chk_wd & STS_CLR))));

endmodule

// File: rtl/bcr_read_port.sv
module bcr_read_port
   import bcr_pkg::*;
#(
   parameter int unsigned NUM_FN = 2,
   parameter int unsigned FN_W   = 3,
   parameter int unsigned OFF_W  = 8,
   localparam int unsigned DEPTH = 1 << OFF_W
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   acc_rd,
   input  logic [FN_W-1:0]                        acc_fn,
   input  logic [OFF_W-1:0]                       acc_off,
   input  logic [NUM_FN-1:0][DEPTH-1:0][BYTE_W-1:0] banks,
   output logic [BYTE_W-1:0]                      rd_data
);

   logic [BYTE_W-1:0] sel_byte;

   always_comb begin
      sel_byte = 8'hFF;
      for (int f = 0; f < NUM_FN; f++) begin
         if (acc_fn == FN_W'(f)) sel_byte = banks[f][acc_off];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_data <= 8'h00;
      else if (acc_rd) rd_data <= sel_byte;
   end

   p_rd_unimpl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_fn >= FN_W'(NUM_FN)) |=> (rd_data == 8'hFF));

   p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(rd_data));

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
   import bcr_pkg::*;
#(
   parameter int unsigned FN_W  = 3,
   parameter int unsigned OFF_W = 8,
   parameter logic [(1<<OFF_W)*8-1:0] F0_RESET = '0,
   parameter logic [(1<<OFF_W)*8-1:0] F1_RESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FN_W-1:0]  acc_fn,
   input  logic [OFF_W-1:0] acc_off,
   input  logic [7:0]       acc_wdata,
   input  logic             acc_wr,
   input  logic             acc_rd,
   output logic [7:0]       rd_data,
   output logic [7:0]       shadow_c_o,
   output logic [7:0]       shadow_d_o,
   output logic [7:0]       shadow_ef_o
);

   localparam int unsigned NUM_FN = 2;
   localparam int unsigned DEPTH  = 1 << OFF_W;

   if (OFF_W != 8) begin : g_bad_off
      $error("bridge_cfg_regs: register map needs OFF_W == 8");
   end
   if (FN_W < 1 || (1 << FN_W) < NUM_FN) begin : g_bad_fn
      $error("bridge_cfg_regs: FN_W too small for two functions");
   end

   logic [NUM_FN-1:0][DEPTH-1:0][BYTE_W-1:0] banks;

   for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
      logic wr_sel;
      assign wr_sel = acc_wr && (acc_fn == FN_W'(f));
      bcr_fn_bank #(
         .FN_ID     (f),
         .OFF_W     (OFF_W),
         .RESET_IMG ((f == 0) ? F0_RESET : F1_RESET)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_sel),
         .off    (acc_off),
         .wdata  (acc_wdata),
         .regs_o (banks[f])
      );
   end

   bcr_read_port #(.NUM_FN(NUM_FN), .FN_W(FN_W), .OFF_W(OFF_W)) rd_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_rd  (acc_rd),
      .acc_fn  (acc_fn),
      .acc_off (acc_off),
      .banks   (banks),
      .rd_data (rd_data)
   );

   assign shadow_c_o  = banks[0][OFF_SHD_C];
   assign shadow_d_o  = banks[0][OFF_SHD_D];
   assign shadow_ef_o = banks[0][OFF_SHD_EF];

   logic rst_n_q;
   always_ff @(posedge clk) rst_n_q <= rst_n;

   always_ff @(posedge clk) begin
      if (rst_n && !rst_n_q) begin
         p_shadow_rst_r9: assert ((shadow_ef_o & SHD_EF_RST_CLR) == 8'h00);
      end
   end

endmodule

// File: tb/bridge_cfg_regs_tb.sv
module bridge_cfg_regs_tb_top;

   localparam int CLK_NS = 10;

   function automatic logic [2047:0] img0();
      logic [2047:0] r = '0;
      r[8'h04*8 +: 8] = 8'hA5;
      r[8'h07*8 +: 8] = 8'hF2;
      r[8'h10*8 +: 8] = 8'h5A;
      r[8'h63*8 +: 8] = 8'hFF;
      return r;
   endfunction

   function automatic logic [2047:0] img1();
      logic [2047:0] r = '0;
      r[8'h07*8 +: 8] = 8'h3C;
      r[8'h1B*8 +: 8] = 8'h77;
      return r;
   endfunction

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] acc_fn = '0;
   logic [7:0] acc_off = '0;
   logic [7:0] acc_wdata = '0;
   logic       acc_wr = 1'b0;
   logic       acc_rd = 1'b0;
   logic [7:0] rd_data, sh_c, sh_d, sh_ef;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   bridge_cfg_regs #(.F0_RESET(img0()), .F1_RESET(img1())) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_fn(acc_fn), .acc_off(acc_off),
      .acc_wdata(acc_wdata), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .rd_data(rd_data), .shadow_c_o(sh_c), .shadow_d_o(sh_d), .shadow_ef_o(sh_ef)
   );

   // {write?, fn, offset, wdata, expected read-back}
   localparam int NV = 49;
   localparam logic [27:0] VEC [NV] = '{
      {1'b1,3'd0,8'h04,8'hFF,8'hE5}, // R5
      {1'b1,3'd0,8'h04,8'h00,8'hA5}, // R5
      {1'b1,3'd0,8'h07,8'hFF,8'h42}, // R6
      {1'b1,3'd0,8'h07,8'h02,8'h42}, // R6
      {1'b1,3'd0,8'h12,8'hAB,8'hA0}, // R7
      {1'b1,3'd0,8'h13,8'hAB,8'hAB}, // R7
      {1'b1,3'd0,8'h03,8'h55,8'h00}, // R3
      {1'b1,3'd0,8'h10,8'h00,8'h5A}, // R3
      {1'b1,3'd0,8'h50,8'h3C,8'h3C}, // R11
      {1'b1,3'd0,8'h4F,8'h11,8'h00}, // R3
      {1'b1,3'd0,8'h78,8'h22,8'h22}, // R11
      {1'b1,3'd0,8'h79,8'h22,8'h00}, // R3
      {1'b1,3'd0,8'h7D,8'h22,8'h00}, // R3
      {1'b1,3'd0,8'h7E,8'h33,8'h33}, // R11
      {1'b1,3'd0,8'h87,8'h11,8'h00}, // R3
      {1'b1,3'd0,8'h88,8'h11,8'h11}, // R11
      {1'b1,3'd0,8'hA7,8'h12,8'h00}, // R3
      {1'b1,3'd0,8'hAC,8'h66,8'h66}, // R11
      {1'b1,3'd0,8'hAD,8'h66,8'h00}, // R3
      {1'b1,3'd0,8'hFC,8'h44,8'h00}, // R3
      {1'b1,3'd0,8'hFD,8'h44,8'h44}, // R11
      {1'b1,3'd0,8'h0D,8'h77,8'h77}, // R11
      {1'b1,3'd0,8'h14,8'h01,8'h00}, // R3
      {1'b1,3'd1,8'h04,8'hFF,8'h47}, // R5
      {1'b1,3'd1,8'h04,8'hB8,8'h00}, // R5
      {1'b1,3'd1,8'h07,8'hFF,8'h0C}, // R6
      {1'b1,3'd1,8'h1B,8'h12,8'h77}, // R4
      {1'b1,3'd1,8'h1A,8'h12,8'h12}, // R11
      {1'b1,3'd1,8'h1C,8'h9F,8'h9F}, // R11
      {1'b1,3'd1,8'h20,8'hFF,8'hF0}, // R8
      {1'b1,3'd1,8'h22,8'h3C,8'h30}, // R8
      {1'b1,3'd1,8'h24,8'h81,8'h80}, // R8
      {1'b1,3'd1,8'h26,8'h0F,8'h00}, // R8
      {1'b1,3'd1,8'h21,8'h0F,8'h0F}, // R11
      {1'b1,3'd1,8'h42,8'hEE,8'hEE}, // R11
      {1'b1,3'd1,8'h43,8'hEE,8'h00}, // R4
      {1'b1,3'd1,8'h3E,8'h05,8'h05}, // R11
      {1'b1,3'd1,8'h3D,8'h05,8'h00}, // R4
      {1'b1,3'd1,8'h1E,8'h01,8'h00}, // R4
      {1'b1,3'd1,8'h17,8'h01,8'h00}, // R4
      {1'b1,3'd1,8'h18,8'h09,8'h09}, // R11
      {1'b1,3'd1,8'hFF,8'h09,8'h00}, // R4
      {1'b1,3'd2,8'h50,8'h99,8'hFF}, // R2
      {1'b0,3'd0,8'h50,8'h00,8'h3C}, // R2
      {1'b1,3'd7,8'h42,8'h55,8'hFF}, // R2
      {1'b0,3'd1,8'h42,8'h00,8'hEE}, // R2
      {1'b1,3'd0,8'h12,8'h5F,8'h50}, // R7
      {1'b0,3'd1,8'h12,8'h00,8'h00}, // R1
      {1'b0,3'd0,8'h13,8'h00,8'hAB}  // R1
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr_cyc(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d);
      @(negedge clk);
      acc_fn = f; acc_off = o; acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd_cyc(input logic [2:0] f, input logic [7:0] o, output logic [7:0] v);
      @(negedge clk);
      acc_fn = f; acc_off = o; acc_rd = 1'b1;
      @(negedge clk);
      acc_rd = 1'b0;
      v = rd_data;
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset rd_data", rd_data, 8'h00);
      check("R9 shadow_c reset", sh_c, 8'h00);
      check("R9 shadow_d reset", sh_d, 8'h00);
      check("R9 shadow_ef forced bits", sh_ef, 8'hCF);
      rd_cyc(3'd0, 8'h63, v); check("R9 f0 0x63", v, 8'hCF);
      rd_cyc(3'd0, 8'h04, v); check("R9 f0 0x04", v, 8'hA5);
      rd_cyc(3'd1, 8'h07, v); check("R9 f1 0x07", v, 8'h3C);
      rd_cyc(3'd1, 8'h1B, v); check("R9 f1 0x1B", v, 8'h77);

      for (int i = 0; i < NV; i++) begin
         logic [27:0] e;
         e = VEC[i];
         if (e[27]) wr_cyc(e[26:24], e[23:16], e[15:8]);
         rd_cyc(e[26:24], e[23:16], v);
         check($sformatf("vector %0d fn%0d off %02h", i, e[26:24], e[23:16]), v, e[7:0]);
      end

      // R10: shadow outputs follow writes
      wr_cyc(3'd0, 8'h61, 8'h5A); check("R10 shadow_c", sh_c, 8'h5A);
      wr_cyc(3'd0, 8'h62, 8'hC3); check("R10 shadow_d", sh_d, 8'hC3);
      wr_cyc(3'd0, 8'h63, 8'h30); check("R10 shadow_ef", sh_ef, 8'h30);
      wr_cyc(3'd1, 8'h61, 8'hEE); check("R10 other fn leaves shadow_c", sh_c, 8'h5A);

      // R1: rd_data holds with no read strobe
      rd_cyc(3'd0, 8'h62, v);
      acc_off = 8'h61;
      repeat (2) @(negedge clk);
      check("R1 hold", rd_data, 8'hC3);

      // R9: reset again restores image and clears forced bits
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 re-reset shadow_ef", sh_ef, 8'hCF);
      check("R9 re-reset shadow_c", sh_c, 8'h00);
      rd_cyc(3'd0, 8'h13, v); check("R9 re-reset f0 0x13", v, 8'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule